// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a 32-bit bus master port and a word-addressed memory or register space. Two address windows, called alias windows, are decoded: one for the SRAM area and one for the peripheral area. Each 32-bit word in an alias window stands for one bit of the matching target window. A read of such a word returns that single bit, zero-extended. A write to such a word changes only that bit. The block does this as an indivisible read-modify-write on the downstream port. Any address outside the alias windows goes downstream unchanged.

Only the privileged CPU master may use the alias windows. The CPU is identified by a master-ID input that is compared against a parameter. If another master, such as a DMA engine, targets an alias address, the block answers with an error and does not touch the memory. The request port uses a plain valid/ready handshake. The downstream port drives a synchronous memory whose read data is valid one cycle after the access is issued.

Top module: `bit_alias_bridge`

## Requirements
- R1: After reset, `reqReady` is 1 and both `rspValid` and `memEn` are 0.
- R2: An access outside both alias windows reaches the memory port with its address, write data and byte strobes unchanged. It causes exactly one memory access. `rspValid` is high for one cycle, in the second cycle after the accepting edge. For a read, `rspRdata` equals the stored word.
- R3: Alias address = alias base + byte offset × 32 + bit number × 4. The SRAM pair uses alias base 0x2200_0000 and target base 0x2000_0000. The peripheral pair uses alias base 0x4200_0000 and target base 0x4000_0000. Each target window spans 1 MB and each alias window spans 32 MB. Bytes are little endian: byte offset k maps to bits 8·(k mod 4) and up of the word at offset k with bits [1:0] cleared. For example, 0x2200_6008 selects bit 2 of the byte at 0x2000_0300.
- R4: A CPU read of an alias word returns 0x0000_0001 if the target bit is set and 0x0000_0000 if it is clear. It makes one memory read, and the response comes in the second cycle after acceptance.
- R5: A CPU write to an alias word sets the target bit to bit 0 of the write data. Every other bit of the memory word is unchanged. The remaining write-data bits and the request byte strobes have no effect.
- R6: An alias write is a memory read followed by a memory write to the same word address. The response comes in the fourth cycle after acceptance. `reqReady` stays low, and no other request is taken, from acceptance until the response.
- R7: The write-back of an alias write asserts exactly one byte strobe: the one for the lane that holds the target bit.
- R8: When a master whose ID differs from `CPU_ID` accesses an alias window, the response is `rspErr` = 1 with `rspRdata` = 0, in the first cycle after acceptance, and no memory access is made. Non-CPU accesses outside the alias windows behave as in R2.
- R9: `rspRdata` is 0 in every write response. `rspErr` is 0 in every response not covered by R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| reqAddr | input | ADDR_W | Byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data |
| reqStrb | input | 4 | Byte strobes for pass-through writes |
| reqMaster | input | MID_W | Master identifier |
| memEn | output | 1 | Downstream access enable |
| memWe | output | 1 | Downstream write enable |
| memAddr | output | ADDR_W | Downstream word-aligned byte address |
| memWdata | output | 32 | Downstream write data |
| memStrb | output | 4 | Downstream byte strobes |
| memRdata | input | 32 | Downstream read data, valid the cycle after a read |
| rspValid | output | 1 | Response valid (one cycle) |
| rspErr | output | 1 | Error response |
| rspRdata | output | 32 | Response read data |

## Verification
The bench builds the block with a 2-bit master ID and `CPU_ID` = 1. A design that hard-wires master 0 as privileged therefore answers wrongly, and both lower and higher non-CPU IDs are exercised. The window bases and the 1 MB span keep their defaults. Directed accesses hit the last alias word of the SRAM window (byte offset 0xFFFFF, bit 7) and the words just below and above that window. This covers the decode edges and the top bit lane. Random accesses stay within the first 512 bytes of each target window, so alias reads and writes fall repeatedly on words that were written earlier through both paths.

// File: rtl/bab_pkg.sv
package bab_pkg;
  localparam int BAB_DATA_W = 32;
  localparam int BAB_LANES  = BAB_DATA_W / 8;
  localparam int BAB_BIT_W  = $clog2(BAB_DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PASS, ST_ARD, ST_ACAP, ST_AWR, ST_RESP, ST_FAULT
  } bab_state_t;

  typedef struct packed {
    logic load;      // latch the request
    logic memIssue;  // drive a downstream access
    logic memWrite;  // downstream access is a write
    logic capture;   // store the read word of a read-modify-write
    logic respond;   // response cycle
    logic fault;     // error response
  } bab_strobe_t;
endpackage

// File: rtl/bab_region_decode.sv
module bab_region_decode #(
  parameter int ADDR_W        = 32,
  parameter int NUM_REGIONS   = 2,
  parameter int TGT_SPAN_LOG2 = 20,
  parameter logic [NUM_REGIONS*ADDR_W-1:0] TGT_BASES   = '0,
  parameter logic [NUM_REGIONS*ADDR_W-1:0] ALIAS_BASES = '0
) (
  input  logic [ADDR_W-3:0]           wordAddr,
  output logic                        aliasHit,
  output logic [ADDR_W-1:0]           tgtAddr,
  output logic [bab_pkg::BAB_BIT_W-1:0] bitIdx
);
  localparam int ALIAS_LOG2 = TGT_SPAN_LOG2 + bab_pkg::BAB_BIT_W;

  logic [NUM_REGIONS-1:0] hitVec;
  logic [ADDR_W-1:0]      tgtVec [NUM_REGIONS];
  logic [ALIAS_LOG2-3:0]  offset;

  assign offset = wordAddr[ALIAS_LOG2-3:0];
  assign bitIdx = offset[bab_pkg::BAB_BIT_W-1:0];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    localparam logic [ADDR_W-1:0] TBASE = TGT_BASES[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] ABASE = ALIAS_BASES[g*ADDR_W +: ADDR_W];
    assign hitVec[g] = (wordAddr[ADDR_W-3:ALIAS_LOG2-2] == ABASE[ADDR_W-1:ALIAS_LOG2]);
    assign tgtVec[g] = {TBASE[ADDR_W-1:TGT_SPAN_LOG2], offset[ALIAS_LOG2-3:5], 2'b00};
  end

  always_comb begin
    aliasHit = |hitVec;
    tgtAddr  = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (hitVec[r]) tgtAddr = tgtAddr | tgtVec[r];
    end
  end
endmodule

// File: rtl/bab_ctrl.sv
module bab_ctrl
  import bab_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        aliasHit,
  input  logic        cpuMaster,
  output logic        reqReady,
  output bab_strobe_t stb
);
  bab_state_t state, stateNext;
  logic       wrFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wrFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.load) wrFlag <= reqWrite;
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.load = 1'b1;
          if (aliasHit && !cpuMaster) stateNext = ST_FAULT;
          else if (aliasHit)          stateNext = ST_ARD;
          else                        stateNext = ST_PASS;
        end
      end
      ST_PASS: begin
        stb.memIssue = 1'b1;
        stb.memWrite = wrFlag;
        stateNext    = ST_RESP;
      end
      ST_ARD: begin
        stb.memIssue = 1'b1;
        stateNext    = wrFlag ? ST_ACAP : ST_RESP;
      end
      ST_ACAP: begin
        stb.capture = 1'b1;
        stateNext   = ST_AWR;
      end
      ST_AWR: begin
        stb.memIssue = 1'b1;
        stb.memWrite = 1'b1;
        stateNext    = ST_RESP;
      end
      ST_RESP: begin
        stb.respond = 1'b1;
        stateNext   = ST_IDLE;
      end
      ST_FAULT: begin
        stb.respond = 1'b1;
        stb.fault   = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/bab_datapath.sv
module bab_datapath
  import bab_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bab_strobe_t           stb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqWrite,
  input  logic [BAB_DATA_W-1:0] reqWdata,
  input  logic [BAB_LANES-1:0]  reqStrb,
  input  logic                  aliasHit,
  input  logic [ADDR_W-1:0]     tgtAddr,
  input  logic [BAB_BIT_W-1:0]  bitIdx,
  input  logic [BAB_DATA_W-1:0] memRdata,
  output logic                  memEn,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [BAB_DATA_W-1:0] memWdata,
  output logic [BAB_LANES-1:0]  memStrb,
  output logic                  rspValid,
  output logic                  rspErr,
  output logic [BAB_DATA_W-1:0] rspRdata
);
  logic [ADDR_W-1:0]     holdAddr;
  logic                  holdWrite;
  logic [BAB_DATA_W-1:0] holdWdata;
  logic [BAB_LANES-1:0]  holdStrb;
  logic                  holdAlias;
  logic [BAB_BIT_W-1:0]  holdBit;
  logic [BAB_DATA_W-1:0] capWord;
  logic [BAB_DATA_W-1:0] mergedWord;
  logic [BAB_LANES-1:0]  laneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAddr  <= '0;
      holdWrite <= 1'b0;
      holdWdata <= '0;
      holdStrb  <= '0;
      holdAlias <= 1'b0;
      holdBit   <= '0;
      capWord   <= '0;
    end else begin
      if (stb.load) begin
        holdAddr  <= aliasHit ? tgtAddr : reqAddr;
        holdWrite <= reqWrite;
        holdWdata <= reqWdata;
        holdStrb  <= reqStrb;
        holdAlias <= aliasHit;
        holdBit   <= bitIdx;
      end
      if (stb.capture) capWord <= memRdata;
    end
  end

  always_comb begin
    mergedWord          = capWord;
    mergedWord[holdBit] = holdWdata[0];
    laneMask            = '0;
    laneMask[holdBit[BAB_BIT_W-1:3]] = 1'b1;
  end

  assign memEn    = stb.memIssue;
  assign memWe    = stb.memIssue && stb.memWrite;
  assign memAddr  = holdAddr;
  assign memWdata = holdAlias ? mergedWord : holdWdata;
  assign memStrb  = holdAlias ? laneMask : holdStrb;

  assign rspValid = stb.respond;
  assign rspErr   = stb.respond && stb.fault;

  always_comb begin
    rspRdata = '0;
    if (stb.respond && !stb.fault && !holdWrite) begin
      if (holdAlias) rspRdata = {{(BAB_DATA_W-1){1'b0}}, memRdata[holdBit]};
      else           rspRdata = memRdata;
    end
  end
endmodule

// File: rtl/bit_alias_bridge.sv
module bit_alias_bridge
  import bab_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int MID_W         = 2,
  parameter int CPU_ID        = 0,
  parameter int TGT_SPAN_LOG2 = 20,
  parameter logic [31:0] SRAM_TGT_BASE    = 32'h2000_0000,
  parameter logic [31:0] SRAM_ALIAS_BASE  = 32'h2200_0000,
  parameter logic [31:0] PERI_TGT_BASE    = 32'h4000_0000,
  parameter logic [31:0] PERI_ALIAS_BASE  = 32'h4200_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqWrite,
  input  logic [31:0]           reqWdata,
  input  logic [3:0]            reqStrb,
  input  logic [MID_W-1:0]      reqMaster,
  output logic                  memEn,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [31:0]           memWdata,
  output logic [3:0]            memStrb,
  input  logic [31:0]           memRdata,
  output logic                  rspValid,
  output logic                  rspErr,
  output logic [31:0]           rspRdata
);
  localparam int NUM_REGIONS = 2;

  bab_strobe_t           stb;
  logic                  aliasHit;
  logic                  cpuMaster;
  logic [ADDR_W-1:0]     tgtAddr;
  logic [BAB_BIT_W-1:0]  bitIdx;

  assign cpuMaster = (reqMaster == MID_W'(CPU_ID));

  bab_region_decode #(
    .ADDR_W        (ADDR_W),
    .NUM_REGIONS   (NUM_REGIONS),
    .TGT_SPAN_LOG2 (TGT_SPAN_LOG2),
    .TGT_BASES     ({ADDR_W'(PERI_TGT_BASE),   ADDR_W'(SRAM_TGT_BASE)}),
    .ALIAS_BASES   ({ADDR_W'(PERI_ALIAS_BASE), ADDR_W'(SRAM_ALIAS_BASE)})
  ) uDecode (
    .wordAddr (reqAddr[ADDR_W-1:2]),
    .aliasHit (aliasHit),
    .tgtAddr  (tgtAddr),
    .bitIdx   (bitIdx)
  );

  bab_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .aliasHit  (aliasHit),
    .cpuMaster (cpuMaster),
    .reqReady  (reqReady),
    .stb       (stb)
  );

  bab_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .reqStrb  (reqStrb),
    .aliasHit (aliasHit),
    .tgtAddr  (tgtAddr),
    .bitIdx   (bitIdx),
    .memRdata (memRdata),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memStrb  (memStrb),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .rspRdata (rspRdata)
  );
endmodule

// File: rtl/bab_checker.sv
module bab_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        memStrb,
  input logic              rspValid,
  input logic              rspErr
);
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);  // R2

  AST_FAULT_IS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);  // R8

  AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (!memEn && !$past(memEn)));  // R8

  AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> !reqReady);  // R6

  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && !$past(reqReady)) |->
      ($past(memEn, 2) && !$past(memWe, 2) && ($past(memAddr, 2) == memAddr)));  // R6

  AST_RMW_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && !$past(reqReady)) |-> ($countones(memStrb) == 1));  // R7
endmodule

bind bit_alias_bridge bab_checker #(.ADDR_W(ADDR_W)) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .memEn    (memEn),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memStrb  (memStrb),
  .rspValid (rspValid),
  .rspErr   (rspErr)
);

// File: tb/tb_bit_alias_bridge.sv
module tb_bit_alias_bridge;
  localparam int MID_W  = 2;
  localparam int CPU_ID = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqStrb = '0;
  logic [MID_W-1:0] reqMaster = '0;
  logic        memEn, memWe;
  logic [31:0] memAddr, memWdata;
  logic [3:0]  memStrb;
  logic [31:0] memRdata = '0;
  logic        rspValid, rspErr;
  logic [31:0] rspRdata;

  int checks = 0;
  int errors = 0;
  int memCnt = 0;

  logic [31:0] mem    [256];
  logic [31:0] shadow [256];

  always #10 clk = ~clk;

  bit_alias_bridge #(.MID_W(MID_W), .CPU_ID(CPU_ID)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .reqStrb(reqStrb), .reqMaster(reqMaster), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memStrb(memStrb),
    .memRdata(memRdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata)
  );

  function automatic int midx(input logic [31:0] a);
    return int'({a[30], a[8:2]});
  endfunction

  // memory model: one-cycle read latency, byte-strobed writes
  always @(posedge clk) begin
    if (memEn) begin
      memCnt = memCnt + 1;
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memStrb[b]) mem[midx(memAddr)][b*8 +: 8] <= memWdata[b*8 +: 8];
      end
      memRdata <= mem[midx(memAddr)];
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tgtBase(input int r);
    return (r == 0) ? 32'h2000_0000 : 32'h4000_0000;
  endfunction
  function automatic logic [31:0] aliasBase(input int r);
    return (r == 0) ? 32'h2200_0000 : 32'h4200_0000;
  endfunction

  task automatic doTxn(input logic [31:0] addr, input bit wr, input logic [31:0] wd,
                       input logic [3:0] strb, input logic [MID_W-1:0] mid,
                       input int expLat, input int expCnt, input bit expErr,
                       input logic [31:0] expData, input string tag);
    int lat;
    bit busyOk;
    @(negedge clk);
    check(reqReady == 1'b1, "R6", "ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr; reqWdata = wd;
    reqStrb = strb; reqMaster = mid;
    memCnt = 0;
    @(posedge clk);
    lat = 0;
    busyOk = 1'b1;
    do begin
      @(negedge clk);
      reqValid = 1'b0;
      reqWdata = $urandom;
      lat++;
      if (reqReady) busyOk = 1'b0;
    end while (!rspValid && lat < 8);
    check(busyOk, "R6", "ready low while busy", 32'(busyOk), 32'd1);
    check(lat == expLat, tag, "response latency", 32'(lat), 32'(expLat));
    check(memCnt == expCnt, tag, "memory access count", 32'(memCnt), 32'(expCnt));
    check(rspErr == expErr, expErr ? "R8" : "R9", "error flag", 32'(rspErr), 32'(expErr));
    check(rspRdata == expData, wr ? "R9" : tag, "read data", rspRdata, expData);
  endtask

  task automatic passOp(input logic [31:0] addr, input bit wr, input logic [31:0] wd,
                        input logic [3:0] strb, input logic [MID_W-1:0] mid);
    logic [31:0] expData;
    expData = '0;
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (strb[b]) shadow[midx(addr)][b*8 +: 8] = wd[b*8 +: 8];
    end else expData = shadow[midx(addr)];
    doTxn(addr, wr, wd, strb, mid, 2, 1, 1'b0, expData, "R2");
  endtask

  task automatic aliasOp(input int r, input int byteOff, input int bitN, input bit wr,
                         input logic [31:0] wd, input logic [MID_W-1:0] mid);
    logic [31:0] aAddr, tWord;
    int bpos;
    aAddr = aliasBase(r) + 32'(byteOff) * 32 + 32'(bitN) * 4;   // R3
    tWord = tgtBase(r) + (32'(byteOff) & ~32'd3);
    bpos  = (byteOff % 4) * 8 + bitN;
    if (mid != MID_W'(CPU_ID)) begin
      doTxn(aAddr, wr, wd, 4'hF, mid, 1, 0, 1'b1, 32'd0, "R8");
    end else if (wr) begin
      shadow[midx(tWord)][bpos] = wd[0];
      doTxn(aAddr, 1'b1, wd, 4'($urandom), mid, 4, 2, 1'b0, 32'd0, "R5");
    end else begin
      doTxn(aAddr, 1'b0, wd, 4'($urandom), mid, 2, 1, 1'b0,
            {31'd0, shadow[midx(tWord)][bpos]}, "R4");
    end
  endtask

  function automatic logic [MID_W-1:0] otherMid();
    logic [MID_W-1:0] m;
    m = MID_W'($urandom);
    if (m == MID_W'(CPU_ID)) m = m + 1'b1;
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i]    = $urandom;
      shadow[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "reset ready", 32'(reqReady), 32'd1);
    check(rspValid == 1'b0, "R1", "reset rspValid", 32'(rspValid), 32'd0);
    check(memEn == 1'b0, "R1", "reset memEn", 32'(memEn), 32'd0);

    // R3 worked example: bit 2 of byte 0x2000_0300 via 0x2200_6008
    passOp(32'h2000_0300, 1'b1, 32'h0000_0000, 4'hF, MID_W'(CPU_ID));
    aliasOp(0, 32'h300, 2, 1'b1, 32'h0000_0001, MID_W'(CPU_ID));
    passOp(32'h2000_0300, 1'b0, 32'h0, 4'h0, MID_W'(CPU_ID));
    check(shadow[midx(32'h2000_0300)] == 32'h4, "R3", "example word", shadow[midx(32'h2000_0300)], 32'h4);
    aliasOp(0, 32'h300, 2, 1'b0, 32'h0, MID_W'(CPU_ID));
    aliasOp(0, 32'h300, 1, 1'b0, 32'h0, MID_W'(CPU_ID));
    // R5: only bit 0 of write data counts
    aliasOp(0, 32'h300, 2, 1'b1, 32'hFFFF_FFFE, MID_W'(CPU_ID));
    passOp(32'h2000_0300, 1'b0, 32'h0, 4'h0, MID_W'(CPU_ID));
    // R7: lane 3 / lane 1 of peripheral words
    passOp(32'h4000_0000, 1'b1, 32'hFFFF_FFFF, 4'hF, MID_W'(CPU_ID));
    aliasOp(1, 1, 7, 1'b1, 32'h0, MID_W'(CPU_ID));
    passOp(32'h4000_0000, 1'b0, 32'h0, 4'h0, MID_W'(CPU_ID));
    aliasOp(1, 3, 7, 1'b0, 32'h0, MID_W'(CPU_ID));
    // R3 window edges
    aliasOp(0, 32'hF_FFFF, 7, 1'b1, 32'h1, MID_W'(CPU_ID));
    aliasOp(0, 32'hF_FFFF, 7, 1'b0, 32'h0, MID_W'(CPU_ID));
    passOp(32'h21FF_FFFC, 1'b1, 32'hA5A5_5A5A, 4'b0110, MID_W'(CPU_ID));
    passOp(32'h2400_0000, 1'b0, 32'h0, 4'h0, MID_W'(CPU_ID));
    // R8: non-CPU masters
    aliasOp(0, 32'h300, 2, 1'b1, 32'h1, MID_W'(0));
    aliasOp(1, 5, 3, 1'b0, 32'h0, MID_W'(2));
    passOp(32'h2000_0300, 1'b0, 32'h0, 4'h0, MID_W'(3));

    for (int n = 0; n < 400; n++) begin
      int kind, r;
      kind = int'($urandom % 6);
      r    = int'($urandom % 2);
      case (kind)
        0: passOp(tgtBase(r) + 32'($urandom % 128) * 4, 1'b0, 32'h0, 4'h0, MID_W'(CPU_ID));
        1: passOp(tgtBase(r) + 32'($urandom % 128) * 4, 1'b1, $urandom, 4'($urandom), MID_W'(CPU_ID));
        2: aliasOp(r, int'($urandom % 512), int'($urandom % 8), 1'b0, $urandom, MID_W'(CPU_ID));
        3: aliasOp(r, int'($urandom % 512), int'($urandom % 8), 1'b1, $urandom, MID_W'(CPU_ID));
        4: aliasOp(r, int'($urandom % 512), int'($urandom % 8), 1'($urandom), $urandom, otherMid());
        default: passOp(tgtBase(r) + 32'($urandom % 128) * 4, 1'($urandom), $urandom, 4'($urandom), otherMid());
      endcase
    end

    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) begin
        if (mem[i] !== shadow[i]) begin
          bad++;
          $display("FAIL R5/R7 word %0d: actual %h expected %h", i, mem[i], shadow[i]);
        end
      end
      checks++;
      if (bad != 0) errors++;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule